// File: doc/BRIEF.md
# Debug trigger chain resolver

This block turns raw per-trigger match results into final debug-trap decisions. Ten triggers are grouped into five fixed pairs. Pair p holds triggers 2p and 2p+1. In pair order, the pair kinds are fetch/fetch, store/store, load/load, fetch/store and fetch/load. Upstream comparators supply one hit bit per trigger.

The block applies three settings held in registers:
- a per-trigger enable;
- a per-trigger timing bit, where 0 means trap before the current instruction and 1 means trap at the next instruction;
- a per-pair chain bit.

It reports which triggers fire, split into a fire-now vector and a fire-next vector, with an OR flag for each vector. Two chained triggers fire together only when both hit. If their timing bits disagree, neither fires. A pair made of two store triggers cannot be chained.

The settings are loaded through a valid-qualified write port that carries a trigger index. The hit evaluation is combinational, so a result appears in the same cycle as its hits.

Top module: `trig_chain_resolver`

## Requirements
- R1: After reset every enable, timing and chain bit is 0, so no trigger fires whatever the hit inputs are.
- R2: A write with `wr_valid_i` high changes settings only from the clock edge at which it is sampled. Hits in the same cycle are judged with the old settings. A write with an index of 10 or more changes nothing.
- R3: In an unchained pair, each trigger fires exactly when its hit bit is 1 and it is enabled, independently of its partner.
- R4: A disabled trigger never fires. A chained pair with a disabled member fires neither trigger.
- R5: In a chained pair with equal timing, both triggers fire when both are enabled and both hit. Neither fires if only one hits.
- R6: In a chained pair whose two timing bits differ, neither trigger fires.
- R7: A firing trigger with timing 0 sets its bit in `fire_now_o`. With timing 1 it sets its bit in `fire_next_o`. No bit is ever set in both vectors.
- R8: The chain bit of pair 1 (triggers 2 and 3, both store kind) is ignored, so those two triggers always behave as unchained.
- R9: `any_now_o` is 1 exactly when `fire_now_o` is non-zero, and `any_next_o` is 1 exactly when `fire_next_o` is non-zero.
- R10: A write to trigger k loads the enable and timing of trigger k. When k is even, it also loads the chain bit of pair k/2. A write to an odd index leaves the chain bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_i | input | 10 | Raw match hit per trigger |
| wr_valid_i | input | 1 | Settings write strobe |
| wr_idx_i | input | 4 | Trigger index of the write |
| wr_en_i | input | 1 | Enable value to load |
| wr_timing_i | input | 1 | Timing value to load (0 now, 1 next) |
| wr_chain_i | input | 1 | Chain value for the pair (even index only) |
| fire_now_o | output | 10 | Triggers trapping before the current instruction |
| fire_next_o | output | 10 | Triggers trapping at the next instruction |
| any_now_o | output | 1 | OR of fire_now_o |
| any_next_o | output | 1 | OR of fire_next_o |

## Verification
A settings write and a hit evaluation can fall in the same cycle. The bench provokes this by driving a write together with a hit pattern that the write would change.

The scoreboard expects the first result to follow the old settings. It then holds the hits for one more cycle and expects the result to follow the new settings. Chain and timing changes are also mixed on one pair, so that a timing mismatch must suppress a pair which the chain bit had just joined.

// File: rtl/trig_chain_pkg.sv
package trig_chain_pkg;
  localparam int NUM_PAIRS = 5;

  typedef enum logic [1:0] {
    KIND_FETCH,
    KIND_LOAD,
    KIND_STORE
  } trig_kind_e;

  // fixed kind of each trigger slot
  function automatic trig_kind_e kind_of(input int t);
    case (t)
      0, 1, 6, 8: kind_of = KIND_FETCH;
      2, 3, 7:    kind_of = KIND_STORE;
      default:    kind_of = KIND_LOAD;
    endcase
  endfunction

  // store chained with store is not permitted
  function automatic bit chain_allowed(input int p);
    chain_allowed = !(kind_of(2*p) == KIND_STORE && kind_of(2*p+1) == KIND_STORE);
  endfunction
endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs #(
  parameter int NUM_PAIRS = trig_chain_pkg::NUM_PAIRS,
  parameter int NUM_TRIG  = 2 * NUM_PAIRS,
  parameter int IDX_W     = $clog2(NUM_TRIG)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_valid_i,
  input  logic [IDX_W-1:0]     wr_idx_i,
  input  logic                 wr_en_i,
  input  logic                 wr_timing_i,
  input  logic                 wr_chain_i,
  output logic [NUM_TRIG-1:0]  en_o,
  output logic [NUM_TRIG-1:0]  timing_o,
  output logic [NUM_PAIRS-1:0] chain_o
);
  for (genvar t = 0; t < NUM_TRIG; t++) begin : g_trig
    logic sel;
    assign sel = wr_valid_i && (wr_idx_i == IDX_W'(t));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_o[t]     <= 1'b0;
        timing_o[t] <= 1'b0;
      end else if (sel) begin
        en_o[t]     <= wr_en_i;
        timing_o[t] <= wr_timing_i;
      end
    end
  end

  // chain bit rides on writes to the even member
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic sel;
    assign sel = wr_valid_i && (wr_idx_i == IDX_W'(2*p));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  chain_o[p] <= 1'b0;
      else if (sel) chain_o[p] <= wr_chain_i;
    end
  end
endmodule

// File: rtl/trig_pair_resolve.sv
module trig_pair_resolve #(
  parameter bit CHAIN_OK = 1'b1
) (
  input  logic [1:0] hit_i,
  input  logic [1:0] en_i,
  input  logic [1:0] timing_i,
  input  logic       chain_i,
  output logic [1:0] fire_now_o,
  output logic [1:0] fire_next_o
);
  logic [1:0] live;
  logic [1:0] fire;
  logic       chained;

  assign live = hit_i & en_i;

  if (CHAIN_OK) begin : g_chain
    assign chained = chain_i;
  end else begin : g_nochain
    logic unused;
    assign unused  = chain_i;
    assign chained = 1'b0;
  end

  always_comb begin
    if (chained) begin
      fire = {2{live[0] & live[1] & (timing_i[0] == timing_i[1])}};
    end else begin
      fire = live;
    end
  end

  assign fire_now_o  = fire & ~timing_i;
  assign fire_next_o = fire &  timing_i;
endmodule

// File: rtl/trig_chain_resolver.sv
module trig_chain_resolver #(
  parameter int NUM_PAIRS = trig_chain_pkg::NUM_PAIRS,
  localparam int NUM_TRIG = 2 * NUM_PAIRS,
  localparam int IDX_W    = $clog2(NUM_TRIG)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_TRIG-1:0] hit_i,
  input  logic                wr_valid_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic                wr_en_i,
  input  logic                wr_timing_i,
  input  logic                wr_chain_i,
  output logic [NUM_TRIG-1:0] fire_now_o,
  output logic [NUM_TRIG-1:0] fire_next_o,
  output logic                any_now_o,
  output logic                any_next_o
);
  logic [NUM_TRIG-1:0]  en_q;
  logic [NUM_TRIG-1:0]  timing_q;
  logic [NUM_PAIRS-1:0] chain_q;

  trig_cfg_regs #(.NUM_PAIRS(NUM_PAIRS)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_valid_i  (wr_valid_i),
    .wr_idx_i    (wr_idx_i),
    .wr_en_i     (wr_en_i),
    .wr_timing_i (wr_timing_i),
    .wr_chain_i  (wr_chain_i),
    .en_o        (en_q),
    .timing_o    (timing_q),
    .chain_o     (chain_q)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    trig_pair_resolve #(.CHAIN_OK(trig_chain_pkg::chain_allowed(p))) u_pair (
      .hit_i       (hit_i[2*p +: 2]),
      .en_i        (en_q[2*p +: 2]),
      .timing_i    (timing_q[2*p +: 2]),
      .chain_i     (chain_q[p]),
      .fire_now_o  (fire_now_o[2*p +: 2]),
      .fire_next_o (fire_next_o[2*p +: 2])
    );
  end

  assign any_now_o  = |fire_now_o;
  assign any_next_o = |fire_next_o;
endmodule

// File: rtl/trig_chain_resolver_chk.sv
module trig_chain_resolver_chk #(
  parameter int NUM_PAIRS = trig_chain_pkg::NUM_PAIRS,
  localparam int NUM_TRIG = 2 * NUM_PAIRS,
  localparam int IDX_W    = $clog2(NUM_TRIG)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_TRIG-1:0] hit_i,
  input logic                wr_valid_i,
  input logic [IDX_W-1:0]    wr_idx_i,
  input logic                wr_en_i,
  input logic                wr_timing_i,
  input logic                wr_chain_i,
  input logic [NUM_TRIG-1:0] fire_now_o,
  input logic [NUM_TRIG-1:0] fire_next_o,
  input logic                any_now_o,
  input logic                any_next_o
);
  // settings as observed at the write port
  logic [NUM_TRIG-1:0]  sh_en;
  logic [NUM_TRIG-1:0]  sh_tim;
  logic [NUM_PAIRS-1:0] sh_chain;
  logic [NUM_TRIG-1:0]  fired;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_en    <= '0;
      sh_tim   <= '0;
      sh_chain <= '0;
    end else if (wr_valid_i && int'(wr_idx_i) < NUM_TRIG) begin
      sh_en[wr_idx_i]  <= wr_en_i;
      sh_tim[wr_idx_i] <= wr_timing_i;
      if (!wr_idx_i[0]) sh_chain[wr_idx_i >> 1] <= wr_chain_i;
    end
  end

  assign fired = fire_now_o | fire_next_o;

  AST_NOW_NEXT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_now_o & fire_next_o) == '0);                                          // R7
  AST_FIRE_NEEDS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fired & ~hit_i) == '0);                                                    // R3
  AST_FIRE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fired & ~sh_en) == '0);                                                    // R4
  AST_ANY_NOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(fire_now_o) == 0) == !any_now_o);                               // R9
  AST_ANY_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(fire_next_o) == 0) == !any_next_o);                             // R9

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    if (trig_chain_pkg::chain_allowed(p)) begin : g_ok
      AST_CHAIN_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sh_chain[p] |-> (fired[2*p] == fired[2*p+1]));                          // R5
      AST_CHAIN_MISMATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sh_chain[p] && sh_tim[2*p] != sh_tim[2*p+1]) |-> !fired[2*p] && !fired[2*p+1]); // R6
    end else begin : g_store
      AST_STORE_PAIR_INDEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hit_i[2*p] && sh_en[2*p]) |-> fired[2*p]);                             // R8
    end
  end
endmodule

bind trig_chain_resolver trig_chain_resolver_chk #(.NUM_PAIRS(NUM_PAIRS)) u_chk (.*);

// File: tb/tb_trig_chain_resolver.sv
module tb_trig_chain_resolver;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [9:0] hit_i = '0;
  logic       wr_valid_i = 1'b0;
  logic [3:0] wr_idx_i = '0;
  logic       wr_en_i = 1'b0, wr_timing_i = 1'b0, wr_chain_i = 1'b0;
  logic [9:0] fire_now_o, fire_next_o;
  logic       any_now_o, any_next_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [9:0] m_en = '0, m_tim = '0;
  logic [4:0] m_chain = '0;
  logic [19:0] exp_q[$];
  string       tag_q[$];

  always #10 clk_i = ~clk_i;

  trig_chain_resolver dut (.*);

  function automatic logic [19:0] model(input logic [9:0] h);
    logic [9:0] now, nxt;
    now = '0; nxt = '0;
    for (int p = 0; p < 5; p++) begin
      logic ha, hb, fa, fb;
      ha = h[2*p] & m_en[2*p];
      hb = h[2*p+1] & m_en[2*p+1];
      if (m_chain[p] && p != 1) begin
        fa = ha & hb & (m_tim[2*p] == m_tim[2*p+1]);
        fb = fa;
      end else begin
        fa = ha; fb = hb;
      end
      now[2*p] = fa & ~m_tim[2*p];     nxt[2*p] = fa & m_tim[2*p];
      now[2*p+1] = fb & ~m_tim[2*p+1]; nxt[2*p+1] = fb & m_tim[2*p+1];
    end
    return {nxt, now};
  endfunction

  task automatic model_write(input int idx, input logic e, t, c);
    if (idx < 10) begin
      m_en[idx] = e; m_tim[idx] = t;
      if (idx % 2 == 0) m_chain[idx/2] = c;
    end
  endtask

  task automatic drive_wr(input int idx, input logic e, t, c);
    wr_valid_i = 1'b1; wr_idx_i = 4'(idx);
    wr_en_i = e; wr_timing_i = t; wr_chain_i = c;
  endtask

  task automatic cfg_write(input int idx, input logic e, t, c);
    @(negedge clk_i);
    drive_wr(idx, e, t, c);
    @(negedge clk_i);
    wr_valid_i = 1'b0;
    model_write(idx, e, t, c);
  endtask

  task automatic apply(input logic [9:0] h, input string tag);
    @(negedge clk_i);
    hit_i = h;
    exp_q.push_back(model(h));
    tag_q.push_back(tag);
  endtask

  // write and hit land in the same cycle
  task automatic write_and_hit(input int idx, input logic e, t, c, input logic [9:0] h);
    @(negedge clk_i);
    drive_wr(idx, e, t, c);
    hit_i = h;
    exp_q.push_back(model(h)); tag_q.push_back("R2 same-cycle old settings");
    @(negedge clk_i);
    wr_valid_i = 1'b0;
    model_write(idx, e, t, c);
    exp_q.push_back(model(h)); tag_q.push_back("R2 next-cycle new settings");
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      #5;
      while (exp_q.size() > 0) begin
        logic [19:0] e;
        logic [21:0] act, expv;
        string tg;
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        act  = {any_next_o, any_now_o, fire_next_o, fire_now_o};
        expv = {|e[19:10], |e[9:0], e};
        n_checks++;
        if (act !== expv) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", tg, act, expv);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    n_checks++;
    if ({fire_now_o, fire_next_o, any_now_o, any_next_o} !== '0) begin
      n_fail++;
      $display("FAIL R1 in reset: actual %h expected 0", {fire_now_o, fire_next_o});
    end
    rst_ni = 1'b1;
    apply(10'h3FF, "R1 all hits after reset");

    for (int k = 0; k < 10; k++) cfg_write(k, 1'b1, 1'b0, 1'b0);
    apply(10'h3FF, "R3 all enabled");
    apply(10'h155, "R3 even hits");
    apply(10'h2AA, "R3 odd hits / R9");
    apply(10'h000, "R9 no hits");

    cfg_write(9, 1'b0, 1'b0, 1'b0);
    apply(10'h3FF, "R4 trigger 9 disabled");

    cfg_write(0, 1'b1, 1'b1, 1'b0);
    apply(10'h003, "R7 timing split pair 0");

    cfg_write(0, 1'b1, 1'b1, 1'b1);
    apply(10'h3FF, "R6 chained timing mismatch");
    cfg_write(1, 1'b1, 1'b1, 1'b0);
    apply(10'h3FF, "R10 odd write keeps chain, R5 both fire");
    apply(10'h001, "R5 one hit in chained pair");
    apply(10'h002, "R5 other hit in chained pair");

    cfg_write(4, 1'b1, 1'b0, 1'b1);
    cfg_write(5, 1'b0, 1'b0, 1'b0);
    apply(10'h030, "R4 chained pair with disabled member");

    cfg_write(2, 1'b1, 1'b0, 1'b1);
    apply(10'h004, "R8 store pair stays independent");
    apply(10'h008, "R8 store pair other member");

    cfg_write(12, 1'b0, 1'b1, 1'b0);
    apply(10'h3FF, "R2 out-of-range write ignored");

    write_and_hit(6, 1'b1, 1'b1, 1'b0, 10'h0C0);
    write_and_hit(0, 1'b0, 1'b1, 1'b1, 10'h003);

    repeat (3) @(negedge clk_i);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule